// File: doc/BRIEF.md
# Acknowledged-Link Segment Retransmit Tracker

This block controls the transmit side of a link where the receiver confirms every segment. It takes one segment at a time from a segment buffer and tells the framer to send it. Each send starts an acknowledge timer. While the segment waits for a reply, the block watches two separate pulses from the receive side: a positive acknowledgement and a negative one. A positive acknowledgement releases the segment, and the next one may then be taken. A negative acknowledgement, or a timer expiry, makes the block send the same segment again.

The block counts the sends of the current segment. It does not retry forever. Once a segment has gone out four times and the fourth send also fails, the block raises a resend-limit error and requests a link restart. It then drops back to a link-down state. It leaves that state only when the link is reported down and then up again.

A separate small holder keeps the source buffer's overflow indication visible. When holding is enabled, the flag stays set until the buffer reports that it is empty.

Top module: `rtx_seg_tracker`

## Requirements
- R1: After reset, all pulse outputs, `attempt_count` and `ovf_flag` are 0. No segment is taken before the link is reported up.
- R2: When the tracker is idle, `link_up` is high and `seg_ready` is high, then in the next cycle `seg_take` and `send_strobe` both pulse and `attempt_count` becomes 1.
- R3: If no reply arrives, `timeout_pulse` and `send_strobe` pulse together exactly `TIMEOUT_CYCLES` cycles after the previous send, and `attempt_count` rises by one. No strobe appears between the two sends.
- R4: A `nack_pulse` while waiting causes a resend in the next cycle. The resend increments `attempt_count`, raises no `timeout_pulse`, and restarts the timer.
- R5: An `ack_pulse` while waiting clears `attempt_count` to 0 the next cycle. No further send of that segment follows.
- R6: A failure (NACK or expiry) when `attempt_count` is 4 produces a one-cycle pulse on both `resend_limit_err` and `link_restart_req`. It produces no fifth send and clears `attempt_count` to 0.
- R7: After a restart request, no segment is taken, even with `seg_ready` and `link_up` high, until `link_up` has been seen low and then high again.
- R8: `link_up` going low while waiting abandons the segment. There are no further sends and `attempt_count` becomes 0.
- R9: `ack_pulse` and `nack_pulse` have no effect while no segment is in flight: no send, and `attempt_count` stays 0.
- R10: An `ack_pulse` in the same cycle as timer expiry wins. There is no resend and no `timeout_pulse`.
- R11: With `ovf_hold_en` high, `ovf_flag` sets the cycle after `src_ovf` and stays set until the cycle after `src_empty`. A simultaneous overflow keeps it set. With `ovf_hold_en` low, `ovf_flag` is `src_ovf` delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| link_up | input | 1 | Link reported up |
| seg_ready | input | 1 | Segment buffer holds a segment |
| seg_take | output | 1 | Pulse: segment accepted from the buffer |
| send_strobe | output | 1 | Pulse: framer sends the current segment |
| ack_pulse | input | 1 | Positive acknowledgement received |
| nack_pulse | input | 1 | Negative acknowledgement received |
| timeout_pulse | output | 1 | Pulse: acknowledge timer expired |
| resend_limit_err | output | 1 | Pulse: send limit reached without acknowledgement |
| link_restart_req | output | 1 | Pulse: request link restart |
| attempt_count | output | CNT_W | Sends of the current segment |
| ovf_hold_en | input | 1 | Hold the overflow flag until the buffer is empty |
| src_ovf | input | 1 | Source buffer overflow event |
| src_empty | input | 1 | Source buffer is empty |
| ovf_flag | output | 1 | Overflow status |

## Verification
The bound checker enforces several rules on every cycle:
- A take always comes with a send.
- Every resend raises the attempt count by exactly one.
- The count never exceeds the limit.
- The error always comes with a restart request and never with a send.
- A timeout that does not end the segment always comes with a resend.
- The overflow flag holds while the buffer is not empty.

Some properties depend on what happened before, and only the bench scenarios can show them:
- the exact timer spacing;
- the sweep over every mix of NACK and expiry failures up to the limit;
- acknowledge-versus-expiry priority;
- ignoring stray replies;
- the need for a down-then-up link after a restart.

// File: rtl/rtx_pkg.sv
// Shared types for the retransmit tracker.
package rtx_pkg;
    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,   // link not usable, wait for link-up edge
        ST_IDLE = 2'd1,   // no segment in flight
        ST_WAIT = 2'd2    // segment sent, waiting for a reply
    } trk_state_e;
endpackage

// File: rtl/rtx_ack_timer.sv
// Acknowledge timer. A load restarts a countdown of TIMEOUT_CYCLES cycles.
// expired is high once the countdown reaches zero, and stays high until
// the timer is reloaded or stopped.
// Assumes: load and stop are never high together.
module rtx_ack_timer #(
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic stop,
    output logic expired
);
    localparam int TW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(TIMEOUT_CYCLES - 1);

    logic [TW-1:0] cnt_q;
    logic          run_q;

    // Countdown register with load, stop and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= RELOAD;
            run_q <= 1'b1;
        end else if (stop) begin
            run_q <= 1'b0;
        end else if (run_q && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/rtx_attempt_ctr.sv
// Counts the sends of the segment in flight.
// Assumes: inc is only raised while the value is below MAX_SENDS.
module rtx_attempt_ctr #(
    parameter int MAX_SENDS = 4,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             first,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    logic [CNT_W-1:0] cnt_q;

    // Clear has priority, then first send, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (first) begin
            cnt_q <= CNT_W'(1);
        end else if (inc && cnt_q < CNT_W'(MAX_SENDS)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign value = cnt_q;
endmodule

// File: rtl/rtx_ovf_hold.sv
// Overflow status holder. In hold mode the flag is sticky until the source
// buffer reports empty; a new overflow event wins over the clear. In pass
// mode the flag is the overflow input delayed by one cycle.
module rtx_ovf_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_en,
    input  logic ovf_in,
    input  logic empty_in,
    output logic flag
);
    logic flag_q;

    // Sticky set / clear-on-empty, or plain delay when hold is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (!hold_en) begin
            flag_q <= ovf_in;
        end else if (ovf_in) begin
            flag_q <= 1'b1;
        end else if (empty_in) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/rtx_seg_tracker.sv
// Transmit segment tracker for an acknowledged link.
// It takes one segment at a time, sends it, and times the reply. It resends
// on NACK or timeout. After MAX_SENDS failed sends it raises a resend-limit
// error and a restart request, then waits for the link to go down and up
// again.
// Assumes: ack_pulse and nack_pulse are single-cycle events in this clock
// domain; seg_ready stays high until seg_take.
module rtx_seg_tracker
    import rtx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 256,
    parameter int MAX_SENDS      = 4,
    localparam int CNT_W         = $clog2(MAX_SENDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_up,
    input  logic             seg_ready,
    output logic             seg_take,
    output logic             send_strobe,
    input  logic             ack_pulse,
    input  logic             nack_pulse,
    output logic             timeout_pulse,
    output logic             resend_limit_err,
    output logic             link_restart_req,
    output logic [CNT_W-1:0] attempt_count,
    input  logic             ovf_hold_en,
    input  logic             src_ovf,
    input  logic             src_empty,
    output logic             ovf_flag
);
    trk_state_e state_q, state_d;
    logic       link_prev_q;
    logic       tmr_exp;
    logic       in_wait, got_ack, failed, at_limit;
    logic       do_first, do_resend, do_abort, do_stop;
    logic       take_q, send_q, tmo_q, lim_q;

    // Decode this cycle's events from the state and the reply inputs.
    always_comb begin
        in_wait   = (state_q == ST_WAIT) && link_up;
        got_ack   = in_wait && ack_pulse;
        failed    = in_wait && !ack_pulse && (nack_pulse || tmr_exp);
        at_limit  = (attempt_count == CNT_W'(MAX_SENDS));
        do_first  = (state_q == ST_IDLE) && link_up && seg_ready;
        do_resend = failed && !at_limit;
        do_abort  = failed && at_limit;
        do_stop   = got_ack || do_abort || !link_up;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DOWN: if (link_up && !link_prev_q) state_d = ST_IDLE;
            ST_IDLE: begin
                if (!link_up)      state_d = ST_DOWN;
                else if (do_first) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!link_up)      state_d = ST_DOWN;
                else if (got_ack)  state_d = ST_IDLE;
                else if (do_abort) state_d = ST_DOWN;
            end
            default: state_d = ST_DOWN;
        endcase
    end

    // State, link history and registered output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_DOWN;
            link_prev_q <= 1'b0;
            take_q      <= 1'b0;
            send_q      <= 1'b0;
            tmo_q       <= 1'b0;
            lim_q       <= 1'b0;
        end else begin
            state_q     <= state_d;
            link_prev_q <= link_up;
            take_q      <= do_first;
            send_q      <= do_first || do_resend;
            tmo_q       <= failed && !nack_pulse && tmr_exp;
            lim_q       <= do_abort;
        end
    end

    rtx_ack_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (do_first || do_resend),
        .stop    (do_stop),
        .expired (tmr_exp)
    );

    rtx_attempt_ctr #(.MAX_SENDS(MAX_SENDS), .CNT_W(CNT_W)) u_attempts (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (do_stop),
        .first (do_first),
        .inc   (do_resend),
        .value (attempt_count)
    );

    rtx_ovf_hold u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_en  (ovf_hold_en),
        .ovf_in   (src_ovf),
        .empty_in (src_empty),
        .flag     (ovf_flag)
    );

    assign seg_take         = take_q;
    assign send_strobe      = send_q;
    assign timeout_pulse    = tmo_q;
    assign resend_limit_err = lim_q;
    assign link_restart_req = lim_q;
endmodule

// File: rtl/rtx_seg_tracker_chk.sv
// Checker for rtx_seg_tracker, attached with bind. Observes ports only.
module rtx_seg_tracker_chk #(
    parameter int MAX_SENDS = 4,
    parameter int CNT_W     = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             seg_take,
    input logic             send_strobe,
    input logic             timeout_pulse,
    input logic             resend_limit_err,
    input logic             link_restart_req,
    input logic [CNT_W-1:0] attempt_count,
    input logic             ovf_hold_en,
    input logic             src_empty,
    input logic             ovf_flag
);
    // R2: taking a segment always sends it
    a_r2_take_sends: assert property (@(posedge clk) disable iff (!rst_n)
        seg_take |-> (send_strobe && attempt_count == CNT_W'(1)));

    // R3/R4: each resend raises the count by exactly one
    a_r4_resend_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (send_strobe && !seg_take) |-> (attempt_count - $past(attempt_count)) == CNT_W'(1));

    // R6: count bounded by the send limit
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        attempt_count <= CNT_W'(MAX_SENDS));

    // R6: limit error comes with restart, no send, cleared count
    a_r6_limit_restart: assert property (@(posedge clk) disable iff (!rst_n)
        resend_limit_err |-> (link_restart_req && !send_strobe && attempt_count == '0));

    // R6: error is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resend_limit_err |=> !resend_limit_err);

    // R3: a timeout that does not end the segment resends it
    a_r3_timeout_resends: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_pulse && !resend_limit_err) |-> send_strobe);

    // R7: no take right after a restart request
    a_r7_no_take_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
        link_restart_req |=> !seg_take);

    // R11: held flag stays set while the buffer is not empty
    a_r11_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hold_en && ovf_flag && !src_empty) |=> ovf_flag);
endmodule

bind rtx_seg_tracker rtx_seg_tracker_chk #(.MAX_SENDS(MAX_SENDS), .CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .seg_take         (seg_take),
    .send_strobe      (send_strobe),
    .timeout_pulse    (timeout_pulse),
    .resend_limit_err (resend_limit_err),
    .link_restart_req (link_restart_req),
    .attempt_count    (attempt_count),
    .ovf_hold_en      (ovf_hold_en),
    .src_empty        (src_empty),
    .ovf_flag         (ovf_flag)
);

// File: tb/test_rtx_seg_tracker.sv
// Bench: sweeps every mix of NACK/expiry failures up to the send limit,
// plus priority, link-drop, stray-reply and overflow-flag cases.
module test_rtx_seg_tracker;
    localparam int TO    = 8;
    localparam int LIMIT = 4;
    localparam int CW    = $clog2(LIMIT + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_up = 1'b0, seg_ready = 1'b0, ack_pulse = 1'b0, nack_pulse = 1'b0;
    logic ovf_hold_en = 1'b0, src_ovf = 1'b0, src_empty = 1'b0;
    logic seg_take, send_strobe, timeout_pulse, resend_limit_err, link_restart_req, ovf_flag;
    logic [CW-1:0] attempt_count;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rtx_seg_tracker #(.TIMEOUT_CYCLES(TO), .MAX_SENDS(LIMIT)) i_rtx_seg_tracker (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .seg_ready(seg_ready),
        .seg_take(seg_take), .send_strobe(send_strobe), .ack_pulse(ack_pulse),
        .nack_pulse(nack_pulse), .timeout_pulse(timeout_pulse),
        .resend_limit_err(resend_limit_err), .link_restart_req(link_restart_req),
        .attempt_count(attempt_count), .ovf_hold_en(ovf_hold_en), .src_ovf(src_ovf),
        .src_empty(src_empty), .ovf_flag(ovf_flag)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic link_cycle();
        link_up = 1'b0; step();
        link_up = 1'b1; step();
    endtask

    task automatic send_first();
        seg_ready = 1'b1; step(); seg_ready = 1'b0;
        check("R2 seg_take", seg_take, 1);
        check("R2 send_strobe", send_strobe, 1);
        check("R2 attempt", attempt_count, 1);
    endtask

    // One failure of the current send; sends_done = sends made so far.
    task automatic fail_once(bit by_nack, int sends_done);
        if (by_nack) begin
            nack_pulse = 1'b1; step(); nack_pulse = 1'b0;
            check("R4 no timeout on nack", timeout_pulse, 0);
        end else begin
            for (int j = 1; j < TO; j++) begin
                step();
                check("R3 quiet before expiry", send_strobe, 0);
            end
            step();
            check("R3 timeout pulse", timeout_pulse, 1);
        end
        if (sends_done < LIMIT) begin
            check("R3/R4 resend", send_strobe, 1);
            check("R3/R4 attempt", attempt_count, sends_done + 1);
            check("R6 no early error", resend_limit_err, 0);
        end else begin
            check("R6 no fifth send", send_strobe, 0);
            check("R6 limit error", resend_limit_err, 1);
            check("R6 restart req", link_restart_req, 1);
            check("R6 attempt cleared", attempt_count, 0);
        end
    endtask

    initial begin
        repeat (3) step();
        check("R1 send", send_strobe, 0);
        check("R1 take", seg_take, 0);
        check("R1 err", resend_limit_err, 0);
        check("R1 attempt", attempt_count, 0);
        check("R1 ovf", ovf_flag, 0);
        rst_n = 1'b1;
        seg_ready = 1'b1;
        repeat (3) begin step(); check("R1 no take while down", seg_take, 0); end
        seg_ready = 1'b0;
        link_up = 1'b1; step();

        // R9: stray replies while idle
        ack_pulse = 1'b1; step(); ack_pulse = 1'b0;
        nack_pulse = 1'b1; step(); nack_pulse = 1'b0;
        step();
        check("R9 no send on stray reply", send_strobe, 0);
        check("R9 attempt stays 0", attempt_count, 0);

        // Sweep: k failures with every NACK/expiry pattern
        for (int k = 0; k <= LIMIT; k++) begin
            for (int pat = 0; pat < (1 << k); pat++) begin
                send_first();
                for (int i = 0; i < k; i++) fail_once(pat[i], i + 1);
                if (k < LIMIT) begin
                    ack_pulse = 1'b1; step(); ack_pulse = 1'b0;
                    check("R5 attempt cleared", attempt_count, 0);
                    check("R5 no send on ack", send_strobe, 0);
                    for (int j = 0; j < TO + 2; j++) begin
                        step();
                        check("R5 no resend after ack", send_strobe, 0);
                    end
                end else begin
                    step();
                    check("R6 error is a pulse", resend_limit_err, 0);
                    seg_ready = 1'b1;
                    for (int j = 0; j < 3; j++) begin
                        step();
                        check("R7 no take before relink", seg_take, 0);
                    end
                    seg_ready = 1'b0;
                    link_cycle();
                end
            end
        end

        // R7: take works again after link down/up
        send_first();
        ack_pulse = 1'b1; step(); ack_pulse = 1'b0;

        // R10: ack in the expiry cycle wins
        send_first();
        for (int j = 1; j < TO; j++) step();
        ack_pulse = 1'b1; step(); ack_pulse = 1'b0;
        check("R10 no resend", send_strobe, 0);
        check("R10 no timeout", timeout_pulse, 0);
        check("R10 attempt cleared", attempt_count, 0);

        // R4: timer restarts on the NACK resend
        send_first();
        step(); step();
        nack_pulse = 1'b1; step(); nack_pulse = 1'b0;
        check("R4 resend", send_strobe, 1);
        fail_once(1'b0, 2);
        ack_pulse = 1'b1; step(); ack_pulse = 1'b0;

        // R8: link drop abandons the segment
        send_first();
        step();
        link_up = 1'b0; step();
        check("R8 attempt cleared", attempt_count, 0);
        for (int j = 0; j < TO + 2; j++) begin
            step();
            check("R8 no send after drop", send_strobe, 0);
        end
        link_up = 1'b1; step();

        // R11: overflow flag, hold mode
        ovf_hold_en = 1'b1;
        src_ovf = 1'b1; step(); src_ovf = 1'b0;
        check("R11 set", ovf_flag, 1);
        for (int j = 0; j < 4; j++) begin step(); check("R11 held", ovf_flag, 1); end
        src_empty = 1'b1; src_ovf = 1'b1; step(); src_ovf = 1'b0;
        check("R11 set wins over empty", ovf_flag, 1);
        step();
        check("R11 cleared on empty", ovf_flag, 0);
        src_empty = 1'b0;
        // R11: pass mode
        ovf_hold_en = 1'b0;
        src_ovf = 1'b1; step(); src_ovf = 1'b0;
        check("R11 pass set", ovf_flag, 1);
        step();
        check("R11 pass follows", ovf_flag, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=hung expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule